// File: doc/BRIEF.md
# Four-Pin GPIO Controller with Change Interrupts

This block controls four general-purpose pads from a byte-wide register bus. For each pin, software picks input or output, the output level, and either a push-pull or an open-drain drive. The block drives an output-enable and an output-data line per pin toward the pad ring. It brings pad levels in through a two-stage synchronizer, and software can read those levels back.

Every pin that is an input under register control has a sticky change flag. A rising or a falling level sets the flag. Software clears it by writing a one to that pin's bit in a clear register. A single interrupt line is the OR of the four flags. A per-pin hand-off bit, meant for a remote polling function, is kept and read back. While the bit is set it blocks change detection on that pin, and it has no other effect.

The bus writes on the clock edge when `bus_we` is high. Reads are combinational from `bus_addr`.

Top module: `gpio_ctrl`

## Requirements
- R1: After synchronous reset, the following hold: every pin is an input, output data is 0, every pin is open-drain, every hand-off bit is 0, `pad_oe` is 0 and `irq` is 0. No change flag is set by the pad levels present while reset is released.
- R2: Address 0x103D bits [3:0] hold the hand-off bits. Address 0x103E holds output data in bits [7:4] and direction in bits [3:0], where 1 means input. Address 0x103F bits [3:0] select the drive, where 1 means push-pull. Each of these reads back what was written, and unused bits read as 0.
- R3: For an output pin with open-drain drive, `pad_oe` is the inverse of its output data bit and `pad_out` is 0.
- R4: For an output pin with push-pull drive, `pad_oe` is 1 and `pad_out` equals its output data bit. For an input pin, both are 0.
- R5: Address 0x1121 bits [7:4] return the pad levels of pins 3..0. A pad change before clock edge N becomes visible after edge N+1.
- R6: On a pin that is an input with its hand-off bit at 0, a rising or a falling pad change sets that pin's flag in 0x1121 bits [3:0]. A pad change before edge N sets the flag at edge N+2. The flag stays set.
- R7: A pad change on a pin that is an output, or whose hand-off bit is 1, sets no flag.
- R8: Writing to address 0x1122 clears each flag whose bit is 1. Bits written as 0 leave their flags unchanged.
- R9: When a flag set and a clear of the same pin fall on the same edge, the flag ends up set.
- R10: `irq` is 1 exactly when at least one flag is set.
- R11: Address 0x1122 and every unmapped address read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Register address |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pad_in | input | 4 | Pad input levels, asynchronous |
| pad_oe | output | 4 | Pad driver enable per pin |
| pad_out | output | 4 | Pad driver data per pin |
| irq | output | 1 | OR of the change flags |

## Verification
The assertions assume `pad_in` can change at any time, since it is synchronized inside the block. They also assume the bus address and write strobe stay stable across each clock edge. The stimulus changes pads and bus signals only on falling clock edges. After each pad change the bench waits four cycles before it looks at the flags, so each pin shows at most one level change between checks. Random configurations favour hand-off bits at 0, so that change detection is exercised often. Directed steps cover the same-edge set-and-clear case and the reset with pads held high.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int NPINS  = 4;
    localparam int DATA_W = 2 * NPINS;
    localparam int ADDR_W = 16;

    localparam logic [ADDR_W-1:0] ADDR_HANDOFF = 16'h103D;
    localparam logic [ADDR_W-1:0] ADDR_DIRDAT  = 16'h103E;
    localparam logic [ADDR_W-1:0] ADDR_DRIVE   = 16'h103F;
    localparam logic [ADDR_W-1:0] ADDR_STATUS  = 16'h1121;
    localparam logic [ADDR_W-1:0] ADDR_CLEAR   = 16'h1122;

    typedef logic [NPINS-1:0] pinvec_t;

    typedef struct packed {
        pinvec_t link_poll;
        pinvec_t level;
        pinvec_t is_input;
        pinvec_t push_pull;
    } gpio_cfg_t;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic pinvec_t drive_enable(gpio_cfg_t c);
        return ~c.is_input & (c.push_pull | ~c.level);
    endfunction

    function automatic pinvec_t drive_level(gpio_cfg_t c);
        return ~c.is_input & c.push_pull & c.level;
    endfunction
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  pinvec_t           mon,
    input  pinvec_t           flags,
    output gpio_cfg_t         cfg,
    output pinvec_t           clr_mask,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD_W = DATA_W - NPINS;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.link_poll <= '0;
            cfg.level     <= '0;
            cfg.is_input  <= '1;
            cfg.push_pull <= '0;
        end else if (req.we) begin
            case (req.addr)
                ADDR_HANDOFF: cfg.link_poll <= req.wdata[NPINS-1:0];
                ADDR_DIRDAT: begin
                    cfg.level    <= req.wdata[DATA_W-1:NPINS];
                    cfg.is_input <= req.wdata[NPINS-1:0];
                end
                ADDR_DRIVE:   cfg.push_pull <= req.wdata[NPINS-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        clr_mask = '0;
        if (req.we && req.addr == ADDR_CLEAR)
            clr_mask = req.wdata[NPINS-1:0];
    end

    always_comb begin
        case (req.addr)
            ADDR_HANDOFF: rdata = {{PAD_W{1'b0}}, cfg.link_poll};
            ADDR_DIRDAT:  rdata = {cfg.level, cfg.is_input};
            ADDR_DRIVE:   rdata = {{PAD_W{1'b0}}, cfg.push_pull};
            ADDR_STATUS:  rdata = {mon, flags};
            default:      rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pin_sense.sv
module gpio_pin_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pad,
    input  logic arm,
    input  logic clr,
    output logic level,
    output logic flag
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;
    logic [CHAIN_W-1:0] valid_q;
    logic               flag_q;
    logic               changed;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            valid_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], pad};
            valid_q <= {valid_q[CHAIN_W-2:0], 1'b1};
        end
    end

    assign level   = chain_q[SYNC_STAGES-1];
    assign changed = valid_q[CHAIN_W-1] & (chain_q[SYNC_STAGES-1] ^ chain_q[SYNC_STAGES]);

    always_ff @(posedge clk) begin
        if (rst)                flag_q <= 1'b0;
        else if (changed & arm) flag_q <= 1'b1;
        else if (clr)           flag_q <= 1'b0;
    end

    assign flag = flag_q;
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
    import gpio_pkg::*;
(
    input  gpio_cfg_t cfg,
    output pinvec_t   oe,
    output pinvec_t   dout,
    output pinvec_t   arm
);
    assign oe   = drive_enable(cfg);
    assign dout = drive_level(cfg);
    assign arm  = cfg.is_input & ~cfg.link_poll;
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic              irq
);
    bus_req_t  req;
    gpio_cfg_t cfg;
    pinvec_t   clr_mask, mon, flags, arm;

    assign req = '{we: bus_we, addr: bus_addr, wdata: bus_wdata};

    gpio_regs u_regs (
        .clk(clk), .rst(rst), .req(req), .mon(mon), .flags(flags),
        .cfg(cfg), .clr_mask(clr_mask), .rdata(bus_rdata)
    );

    gpio_pad_drive u_drive (
        .cfg(cfg), .oe(pad_oe), .dout(pad_out), .arm(arm)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_pin_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
            .clk(clk), .rst(rst), .pad(pad_in[i]), .arm(arm[i]),
            .clr(clr_mask[i]), .level(mon[i]), .flag(flags[i])
        );
    end

    assign irq = |flags;
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
    import gpio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pad_out,
    input logic              irq,
    input logic [NPINS-1:0]  is_input,
    input logic [NPINS-1:0]  push_pull,
    input logic [NPINS-1:0]  link_poll,
    input logic [NPINS-1:0]  flags
);
    // R1
    rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0 && irq == 1'b0));

    // R3
    od_low_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_out & ~push_pull) == '0);

    // R4
    input_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & is_input) == '0);

    // R7
    arm_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (flags & ~$past(flags) & ~($past(is_input) & ~$past(link_poll))) == '0);

    // R10
    irq_view_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_STATUS) |-> (irq == (|bus_rdata[NPINS-1:0])));
endmodule

bind gpio_ctrl gpio_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq),
    .is_input(cfg.is_input), .push_pull(cfg.push_pull),
    .link_poll(cfg.link_poll), .flags(flags)
);

// File: tb/test_gpio_ctrl.sv
module test_gpio_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [3:0]  pad_in = 4'b1010;
    logic [3:0]  pad_oe, pad_out;
    logic        irq;

    int errors = 0;
    int checks = 0;

    logic [3:0] m_mode = '0, m_dout = '0, m_dir = '1, m_pp = '0, m_flags = '0;

    gpio_ctrl i_gpio_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [3:0] exp_oe();
        return ~m_dir & (m_pp | ~m_dout);
    endfunction

    function automatic logic [3:0] exp_out();
        return ~m_dir & m_pp & m_dout;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycles(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_all(string tag);
        logic [7:0] d;
        rd(16'h1121, d);
        chk({tag, " R5 R6 status"}, d, {pad_in, m_flags});
        chk({tag, " R10 irq"}, {7'b0, irq}, {7'b0, |m_flags});
        chk({tag, " R3 R4 pad_oe"}, {4'b0, pad_oe}, {4'b0, exp_oe()});
        chk({tag, " R3 R4 pad_out"}, {4'b0, pad_out}, {4'b0, exp_out()});
    endtask

    task automatic set_pads(logic [3:0] v);
        @(negedge clk);
        m_flags = m_flags | ((v ^ pad_in) & m_dir & ~m_mode);
        pad_in = v;
        cycles(4);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd1234));
        cycles(3);
        rst = 1'b0;
        cycles(5);
        // R1 reset state, pads high at release give no flag
        rd(16'h103D, d); chk("R1 handoff", d, 8'h00);
        rd(16'h103E, d); chk("R1 dirdat", d, 8'h0F);
        rd(16'h103F, d); chk("R1 drive", d, 8'h00);
        check_all("R1");

        // R2 read-back with unused bits zero
        wr(16'h103D, 8'hF5); rd(16'h103D, d); chk("R2 handoff", d, 8'h05);
        wr(16'h103D, 8'h00);
        wr(16'h103F, 8'hA6); rd(16'h103F, d); chk("R2 drive", d, 8'h06);
        wr(16'h103E, 8'h5C); rd(16'h103E, d); chk("R2 dirdat", d, 8'h5C);
        m_pp = 4'h6; m_dout = 4'h5; m_dir = 4'hC;
        check_all("R3 R4 mixed");

        // R11 clear register and unmapped reads
        rd(16'h1122, d); chk("R11 clear reads zero", d, 8'h00);
        rd(16'h1040, d); chk("R11 unmapped", d, 8'h00);
        rd(16'h0000, d); chk("R11 unmapped low", d, 8'h00);

        // R6 both edges, R7 output pins ignored
        set_pads(4'b0110);
        check_all("R6 R7 edges");
        // R8 write-0 no effect, write-1 clear
        wr(16'h1122, 8'h00); check_all("R8 zero write");
        wr(16'h1122, 8'h04); m_flags &= ~4'h4; check_all("R8 clear one");

        // R7 hand-off blocks detection
        wr(16'h103E, 8'h0F); m_dir = 4'hF; m_dout = 4'h0;
        wr(16'h103D, 8'h01); m_mode = 4'h1;
        set_pads(pad_in ^ 4'h1);
        check_all("R7 handoff");
        wr(16'h103D, 8'h00); m_mode = 4'h0;
        wr(16'h1122, 8'h0F); m_flags = '0;
        check_all("R8 clear all");

        // R9 set and clear on the same edge
        set_pads(pad_in ^ 4'h1);
        @(negedge clk); pad_in = pad_in ^ 4'h1;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 16'h1122; bus_wdata = 8'h01; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
        cycles(3);
        rd(16'h1121, d); chk("R9 set wins", {7'b0, d[0]}, 8'h01);

        // random phase
        for (int it = 0; it < 300; it++) begin
            int act;
            act = $urandom_range(0, 3);
            if (act == 0) begin
                m_mode = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
                m_dir = 4'($urandom); m_dout = 4'($urandom); m_pp = 4'($urandom);
                wr(16'h103D, {4'h0, m_mode});
                wr(16'h103E, {m_dout, m_dir});
                wr(16'h103F, {4'h0, m_pp});
                cycles(4);
            end else if (act == 3) begin
                logic [3:0] c;
                c = 4'($urandom);
                wr(16'h1122, {4'($urandom), c});
                m_flags &= ~c;
                cycles(1);
            end else begin
                set_pads(4'($urandom));
            end
            check_all("random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule